// File: doc/BRIEF.md
# Port I/O Software Service Bridge

This block sits between a CPU core's stalling port-I/O seam and an AXI-Lite slave window, so that a software processor can act as the device behind selected I/O ports. When the port decoder routes an access here, the bridge latches the 16-bit port number, the direction and any write data. It then keeps the core's acknowledge low and raises a service interrupt toward the processor.

Software reads the latched request through the register window, runs its device model, and writes the result to a completion register. That write releases the core: acknowledge pulses for one cycle with the returned read data beside it. The core is stalled for the whole service time, so how long software takes cannot change the value the instruction sees. Each access is taken once only, so read side-effects in the software model happen exactly once. The processor can also drive device interrupt lines into the fabric through a writable bit register.

Register window, byte offsets: 0x00 status, 0x04 latched port, 0x08 latched write data, 0x0C completion, 0x10 injected interrupt lines. All accesses are full 32-bit words.

Top module: `pio_sw_bridge`

## Requirements
- R1: After reset the bridge is idle: `ioAck` is 0, `reqIrq` is 0, `devIrq` is all zeros and the status register reads 0.
- R2: When `ioReq` is high and the bridge is idle, it latches the request. Status then reads bit0 = 1 (pending) and bit1 = the direction (1 = write, shown only while pending). Offset 0x04 returns the port in bits 15:0 with the upper bits zero, and offset 0x08 returns the write data.
- R3: While a request is pending, `reqIrq` stays 1 and `ioAck` stays 0, for as long as software leaves it unserved.
- R4: A write to 0x0C while a request is pending clears pending and drops `reqIrq`. `ioAck` is 1 for exactly one cycle, the cycle after the write is committed (the same cycle `bvalid` rises), and `ioRdata` equals the written word in that cycle.
- R5: A pending request is latched once only. Changes on the port, direction or data inputs while it is pending do not alter the latched values. A request still held high during the acknowledge cycle is not latched a second time.
- R6: A write to 0x0C while idle has no effect: no acknowledge and no change of status.
- R7: Offset 0x10 is read/write. Its low 16 bits drive `devIrq` directly, and bits above the line count are ignored and read back as zero.
- R8: Every AXI-Lite response is OKAY (`bresp` = `rresp` = 2'b00). A write completes whether address and data arrive together, address first or data first.
- R9: Reads of 0x0C and of any unmapped or unaligned address return 0.
- R10: A status read whose address is accepted in the same cycle a request is latched returns the pre-capture value. A write to 0x10 committed in that same cycle takes effect independently of the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioReq | input | 1 | Routed I/O request, held until acknowledged |
| ioPort | input | 16 | I/O port number |
| ioWrite | input | 1 | Direction, 1 = write |
| ioWdata | input | 32 | Data of an I/O write |
| ioAck | output | 1 | One-cycle completion pulse to the core |
| ioRdata | output | 32 | Read result, valid with `ioAck` |
| reqIrq | output | 1 | Service interrupt to the processor |
| devIrq | output | 16 | Software-driven device interrupt lines |
| sAwValid | input | 1 | AXI-Lite write address valid |
| sAwReady | output | 1 | AXI-Lite write address ready |
| sAwAddr | input | 8 | AXI-Lite write address |
| sWValid | input | 1 | AXI-Lite write data valid |
| sWReady | output | 1 | AXI-Lite write data ready |
| sWData | input | 32 | AXI-Lite write data |
| sBValid | output | 1 | AXI-Lite write response valid |
| sBReady | input | 1 | AXI-Lite write response ready |
| sBResp | output | 2 | AXI-Lite write response |
| sArValid | input | 1 | AXI-Lite read address valid |
| sArReady | output | 1 | AXI-Lite read address ready |
| sArAddr | input | 8 | AXI-Lite read address |
| sRValid | output | 1 | AXI-Lite read data valid |
| sRReady | input | 1 | AXI-Lite read data ready |
| sRData | output | 32 | AXI-Lite read data |
| sRResp | output | 2 | AXI-Lite read response |

## Verification
Three things can land on the same clock edge: latching a core request, a status read being accepted, and a committed write to the interrupt register. The bench lines these up on purpose. It hands over the write address and data one cycle early, so the write commits on the edge where it raises `ioReq` and presents the status read. The read must return the idle value, the interrupt lines must show the new bits and the request must be pending afterwards. A second overlap is the completion write against a request that is still held during the acknowledge cycle. The bench counts the acknowledge pulses and reads status afterwards to confirm the request was not latched again.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;

  // Register window byte offsets
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_PORT   = 'h04;
  localparam int OFS_WDATA  = 'h08;
  localparam int OFS_DONE   = 'h0C;
  localparam int OFS_IRQ    = 'h10;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_PORT,
    SEL_WDATA,
    SEL_DONE,
    SEL_IRQ,
    SEL_NONE
  } regSelT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_ACK
  } bridgeStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   complete;
    logic   irqWe;
    regSelT rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/pio_bridge_dp.sv
module pio_bridge_dp
  import pio_bridge_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        stb,
  input  logic              pending,
  input  logic [PORT_W-1:0] ioPort,
  input  logic              ioWrite,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ioRdata,
  output logic [IRQ_W-1:0]  devIrq,
  output logic [DATA_W-1:0] readWord
);

  logic [PORT_W-1:0] portQ;
  logic              dirQ;
  logic [DATA_W-1:0] wdatQ;
  logic [DATA_W-1:0] rdatQ;
  logic [IRQ_W-1:0]  irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ <= '0;
      dirQ  <= 1'b0;
      wdatQ <= '0;
    end else if (stb.capture) begin
      portQ <= ioPort;
      dirQ  <= ioWrite;
      wdatQ <= ioWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdatQ <= '0;
    end else if (stb.complete) begin
      rdatQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= '0;
    end else if (stb.irqWe) begin
      irqQ <= wrData[IRQ_W-1:0];
    end
  end

  always_comb begin
    readWord = '0;
    case (stb.rdSel)
      SEL_STATUS: begin
        readWord[0] = pending;
        readWord[1] = dirQ & pending;
      end
      SEL_PORT:  readWord = DATA_W'(portQ);
      SEL_WDATA: readWord = wdatQ;
      SEL_IRQ:   readWord = DATA_W'(irqQ);
      default:   readWord = '0;
    endcase
  end

  assign ioRdata = rdatQ;
  assign devIrq  = irqQ;

  // R5
  latched_port_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending && $past(pending) |-> $stable(portQ) && $stable(wdatQ));

  // R2
  capture_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !pending);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.irqWe) |-> $stable(irqQ));

endmodule

// File: rtl/pio_bridge_ctrl.sv
module pio_bridge_ctrl
  import pio_bridge_pkg::*;
#(
  parameter int AXI_ADDR_W = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioReq,
  output logic                  ioAck,
  output logic                  reqIrq,
  output logic                  pending,
  output ctrlStrobeT            stb,
  output logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-1:0]     readWord,
  input  logic                  sAwValid,
  output logic                  sAwReady,
  input  logic [AXI_ADDR_W-1:0] sAwAddr,
  input  logic                  sWValid,
  output logic                  sWReady,
  input  logic [DATA_W-1:0]     sWData,
  output logic                  sBValid,
  input  logic                  sBReady,
  output logic [1:0]            sBResp,
  input  logic                  sArValid,
  output logic                  sArReady,
  input  logic [AXI_ADDR_W-1:0] sArAddr,
  output logic                  sRValid,
  input  logic                  sRReady,
  output logic [DATA_W-1:0]     sRData,
  output logic [1:0]            sRResp
);

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic regSelT decodeAddr(input logic [AXI_ADDR_W-1:0] a);
    if      (a == AXI_ADDR_W'(OFS_STATUS)) return SEL_STATUS;
    else if (a == AXI_ADDR_W'(OFS_PORT))   return SEL_PORT;
    else if (a == AXI_ADDR_W'(OFS_WDATA))  return SEL_WDATA;
    else if (a == AXI_ADDR_W'(OFS_DONE))   return SEL_DONE;
    else if (a == AXI_ADDR_W'(OFS_IRQ))    return SEL_IRQ;
    else                                   return SEL_NONE;
  endfunction

  bridgeStateT           stateQ, stateD;
  logic                  awHeldQ, wHeldQ, bValidQ, rValidQ;
  logic [AXI_ADDR_W-1:0] awAddrQ;
  logic [DATA_W-1:0]     wDataQ, rDataQ;
  logic                  commit, arFire;
  regSelT                wrSel;

  assign commit = awHeldQ && wHeldQ && !bValidQ;
  assign arFire = sArValid && !rValidQ;
  assign wrSel  = decodeAddr(awAddrQ);

  always_comb begin
    stb.capture  = ioReq && (stateQ == ST_IDLE);
    stb.complete = commit && (wrSel == SEL_DONE) && (stateQ == ST_PEND);
    stb.irqWe    = commit && (wrSel == SEL_IRQ);
    stb.rdSel    = decodeAddr(sArAddr);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (stb.capture)  stateD = ST_PEND;
      ST_PEND: if (stb.complete) stateD = ST_ACK;
      ST_ACK:                    stateD = ST_IDLE;
      default:                   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Write channel: address and data are held independently
  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeldQ <= 1'b0;
      wHeldQ  <= 1'b0;
      awAddrQ <= '0;
      wDataQ  <= '0;
      bValidQ <= 1'b0;
    end else begin
      if (sAwValid && !awHeldQ) begin
        awHeldQ <= 1'b1;
        awAddrQ <= sAwAddr;
      end else if (commit) begin
        awHeldQ <= 1'b0;
      end
      if (sWValid && !wHeldQ) begin
        wHeldQ <= 1'b1;
        wDataQ <= sWData;
      end else if (commit) begin
        wHeldQ <= 1'b0;
      end
      if (commit)       bValidQ <= 1'b1;
      else if (sBReady) bValidQ <= 1'b0;
    end
  end

  // Read channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValidQ <= 1'b0;
      rDataQ  <= '0;
    end else if (arFire) begin
      rValidQ <= 1'b1;
      rDataQ  <= readWord;
    end else if (sRReady) begin
      rValidQ <= 1'b0;
    end
  end

  assign pending  = (stateQ == ST_PEND);
  assign reqIrq   = pending;
  assign ioAck    = (stateQ == ST_ACK);
  assign wrData   = wDataQ;
  assign sAwReady = !awHeldQ;
  assign sWReady  = !wHeldQ;
  assign sBValid  = bValidQ;
  assign sBResp   = RESP_OKAY;
  assign sArReady = !rValidQ;
  assign sRValid  = rValidQ;
  assign sRData   = rDataQ;
  assign sRResp   = RESP_OKAY;

  // R4
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioAck |=> !ioAck);

  // R4
  ack_after_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioAck |-> $past(stb.complete));

  // R3
  irq_excludes_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqIrq |-> !ioAck);

  // R8
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sBValid && !sBReady |=> sBValid);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sRValid && !sRReady |=> sRValid && $stable(sRData));

endmodule

// File: rtl/pio_sw_bridge.sv
module pio_sw_bridge
  import pio_bridge_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int DATA_W     = 32,
  parameter int IRQ_W      = 16,
  parameter int AXI_ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioReq,
  input  logic [PORT_W-1:0]     ioPort,
  input  logic                  ioWrite,
  input  logic [DATA_W-1:0]     ioWdata,
  output logic                  ioAck,
  output logic [DATA_W-1:0]     ioRdata,
  output logic                  reqIrq,
  output logic [IRQ_W-1:0]      devIrq,
  input  logic                  sAwValid,
  output logic                  sAwReady,
  input  logic [AXI_ADDR_W-1:0] sAwAddr,
  input  logic                  sWValid,
  output logic                  sWReady,
  input  logic [DATA_W-1:0]     sWData,
  output logic                  sBValid,
  input  logic                  sBReady,
  output logic [1:0]            sBResp,
  input  logic                  sArValid,
  output logic                  sArReady,
  input  logic [AXI_ADDR_W-1:0] sArAddr,
  output logic                  sRValid,
  input  logic                  sRReady,
  output logic [DATA_W-1:0]     sRData,
  output logic [1:0]            sRResp
);

  ctrlStrobeT        stb;
  logic              pending;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] readWord;

  pio_bridge_ctrl #(
    .AXI_ADDR_W(AXI_ADDR_W),
    .DATA_W    (DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ioReq   (ioReq),
    .ioAck   (ioAck),
    .reqIrq  (reqIrq),
    .pending (pending),
    .stb     (stb),
    .wrData  (wrData),
    .readWord(readWord),
    .sAwValid(sAwValid),
    .sAwReady(sAwReady),
    .sAwAddr (sAwAddr),
    .sWValid (sWValid),
    .sWReady (sWReady),
    .sWData  (sWData),
    .sBValid (sBValid),
    .sBReady (sBReady),
    .sBResp  (sBResp),
    .sArValid(sArValid),
    .sArReady(sArReady),
    .sArAddr (sArAddr),
    .sRValid (sRValid),
    .sRReady (sRReady),
    .sRData  (sRData),
    .sRResp  (sRResp)
  );

  pio_bridge_dp #(
    .PORT_W(PORT_W),
    .DATA_W(DATA_W),
    .IRQ_W (IRQ_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pending (pending),
    .ioPort  (ioPort),
    .ioWrite (ioWrite),
    .ioWdata (ioWdata),
    .wrData  (wrData),
    .ioRdata (ioRdata),
    .devIrq  (devIrq),
    .readWord(readWord)
  );

endmodule

// File: tb/pio_sw_bridge_bench.sv
`timescale 1ns/1ps
module pio_sw_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioReq = 1'b0;
  logic [15:0] ioPort = '0;
  logic        ioWrite = 1'b0;
  logic [31:0] ioWdata = '0;
  logic        ioAck;
  logic [31:0] ioRdata;
  logic        reqIrq;
  logic [15:0] devIrq;
  logic        sAwValid = 1'b0, sWValid = 1'b0, sArValid = 1'b0;
  logic        sBReady = 1'b1, sRReady = 1'b1;
  logic [7:0]  sAwAddr = '0, sArAddr = '0;
  logic [31:0] sWData = '0;
  logic        sAwReady, sWReady, sBValid, sArReady, sRValid;
  logic [1:0]  sBResp, sRResp;
  logic [31:0] sRData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pio_sw_bridge u_pio_sw_bridge (
    .clk(clk), .rstN(rstN),
    .ioReq(ioReq), .ioPort(ioPort), .ioWrite(ioWrite), .ioWdata(ioWdata),
    .ioAck(ioAck), .ioRdata(ioRdata), .reqIrq(reqIrq), .devIrq(devIrq),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwAddr(sAwAddr),
    .sWValid(sWValid), .sWReady(sWReady), .sWData(sWData),
    .sBValid(sBValid), .sBReady(sBReady), .sBResp(sBResp),
    .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr),
    .sRValid(sRValid), .sRReady(sRReady), .sRData(sRData), .sRResp(sRResp)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // mode 0: together, 1: address first, 2: data first. Returns at the
  // falling edge where the write response is visible.
  task automatic axiWrite(input logic [7:0] addr, input logic [31:0] data, input int mode);
    int guard;
    @(negedge clk);
    sAwAddr = addr;
    sWData  = data;
    if (mode == 0) begin
      sAwValid = 1'b1; sWValid = 1'b1;
      while (!(sAwReady && sWReady)) @(negedge clk);
      @(negedge clk);
      sAwValid = 1'b0; sWValid = 1'b0;
    end else if (mode == 1) begin
      sAwValid = 1'b1;
      while (!sAwReady) @(negedge clk);
      @(negedge clk);
      sAwValid = 1'b0;
      @(negedge clk);
      sWValid = 1'b1;
      while (!sWReady) @(negedge clk);
      @(negedge clk);
      sWValid = 1'b0;
    end else begin
      sWValid = 1'b1;
      while (!sWReady) @(negedge clk);
      @(negedge clk);
      sWValid = 1'b0;
      @(negedge clk);
      sAwValid = 1'b1;
      while (!sAwReady) @(negedge clk);
      @(negedge clk);
      sAwValid = 1'b0;
    end
    guard = 0;
    while (!sBValid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chkEq("R8 bvalid seen", 32'(sBValid), 32'd1);
    chkEq("R8 bresp OKAY", 32'(sBResp), 32'd0);
  endtask

  task automatic axiRead(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    sArAddr  = addr;
    sArValid = 1'b1;
    while (!sArReady) @(negedge clk);
    @(negedge clk);
    sArValid = 1'b0;
    chkEq("R8 rvalid seen", 32'(sRValid), 32'd1);
    chkEq("R8 rresp OKAY", 32'(sRResp), 32'd0);
    data = sRData;
  endtask

  task automatic raiseReq(input logic [15:0] port, input logic wr, input logic [31:0] d);
    @(negedge clk);
    ioReq = 1'b1; ioPort = port; ioWrite = wr; ioWdata = d;
    @(negedge clk);
  endtask

  // Completion write, then check the one-cycle acknowledge and release the core
  task automatic completeReq(input logic [31:0] rd, input int mode, input string tag);
    logic [31:0] v;
    axiWrite(8'h0C, rd, mode);
    chkEq({tag, " R4 ack high"}, 32'(ioAck), 32'd1);
    chkEq({tag, " R4 rdata"}, ioRdata, rd);
    chkEq({tag, " R4 irq dropped"}, 32'(reqIrq), 32'd0);
    @(negedge clk);
    chkEq({tag, " R4 ack one cycle"}, 32'(ioAck), 32'd0);
    ioReq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chkEq({tag, " R5 no second ack"}, 32'(ioAck), 32'd0);
    end
    axiRead(8'h00, v);
    chkEq({tag, " R5 not recaptured"}, v, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chkEq("R1 ack reset", 32'(ioAck), 32'd0);
    chkEq("R1 irq reset", 32'(reqIrq), 32'd0);
    chkEq("R1 devIrq reset", 32'(devIrq), 32'd0);
    axiRead(8'h00, v);
    chkEq("R1 status reset", v, 32'd0);
  endtask

  task automatic t_writeAccess();
    logic [31:0] v;
    raiseReq(16'h03F8, 1'b1, 32'h0000_0041);
    repeat (6) begin
      chkEq("R3 irq while pending", 32'(reqIrq), 32'd1);
      chkEq("R3 no ack while pending", 32'(ioAck), 32'd0);
      @(negedge clk);
    end
    axiRead(8'h00, v);
    chkEq("R2 status write pending", v, 32'd3);
    axiRead(8'h04, v);
    chkEq("R2 port", v, 32'h0000_03F8);
    axiRead(8'h08, v);
    chkEq("R2 wdata", v, 32'h0000_0041);
    ioPort = 16'h1234; ioWdata = 32'hFFFF_FFFF; ioWrite = 1'b0;
    repeat (2) @(negedge clk);
    axiRead(8'h04, v);
    chkEq("R5 port held", v, 32'h0000_03F8);
    axiRead(8'h08, v);
    chkEq("R5 wdata held", v, 32'h0000_0041);
    axiRead(8'h00, v);
    chkEq("R5 dir held", v, 32'd3);
    completeReq(32'h0, 1, "write/addr-first");
  endtask

  task automatic t_readAccess();
    logic [31:0] v;
    raiseReq(16'h0071, 1'b0, 32'h0);
    axiRead(8'h00, v);
    chkEq("R2 status read pending", v, 32'd1);
    axiRead(8'h04, v);
    chkEq("R2 read port", v, 32'h0000_0071);
    completeReq(32'hDEAD_BEEF, 2, "read/data-first");
    raiseReq(16'hFFFF, 1'b0, 32'h0);
    axiRead(8'h04, v);
    chkEq("R2 max port", v, 32'h0000_FFFF);
    completeReq(32'h0000_00A5, 0, "read/together");
  endtask

  task automatic t_idleComplete();
    logic [31:0] v;
    axiWrite(8'h0C, 32'h1111_2222, 0);
    chkEq("R6 no ack idle", 32'(ioAck), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chkEq("R6 no ack later", 32'(ioAck), 32'd0);
    end
    axiRead(8'h00, v);
    chkEq("R6 status idle", v, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    axiWrite(8'h10, 32'h0000_0150, 0);
    @(negedge clk);
    chkEq("R7 devIrq lines", 32'(devIrq), 32'h0000_0150);
    axiRead(8'h10, v);
    chkEq("R7 irq readback", v, 32'h0000_0150);
    axiWrite(8'h10, 32'hFFFF_FFFF, 1);
    @(negedge clk);
    chkEq("R7 devIrq all", 32'(devIrq), 32'h0000_FFFF);
    axiRead(8'h10, v);
    chkEq("R7 upper ignored", v, 32'h0000_FFFF);
    axiWrite(8'h10, 32'h0, 2);
    @(negedge clk);
    chkEq("R7 devIrq cleared", 32'(devIrq), 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    axiRead(8'h0C, v);
    chkEq("R9 done reads zero", v, 32'd0);
    axiRead(8'h14, v);
    chkEq("R9 unmapped zero", v, 32'd0);
    axiRead(8'h05, v);
    chkEq("R9 unaligned zero", v, 32'd0);
  endtask

  task automatic t_sameCycle();
    logic [31:0] v;
    @(negedge clk);
    sAwAddr = 8'h10; sWData = 32'h0000_0010;
    sAwValid = 1'b1; sWValid = 1'b1;
    @(negedge clk);
    sAwValid = 1'b0; sWValid = 1'b0;
    sArAddr = 8'h00; sArValid = 1'b1;
    ioReq = 1'b1; ioPort = 16'h01F0; ioWrite = 1'b0; ioWdata = '0;
    @(negedge clk);
    sArValid = 1'b0;
    chkEq("R10 read accepted", 32'(sRValid), 32'd1);
    chkEq("R10 status pre-capture", sRData, 32'd0);
    chkEq("R10 irq write landed", 32'(devIrq), 32'h0000_0010);
    chkEq("R10 bvalid", 32'(sBValid), 32'd1);
    chkEq("R10 request captured", 32'(reqIrq), 32'd1);
    axiRead(8'h00, v);
    chkEq("R10 status after", v, 32'd1);
    axiRead(8'h04, v);
    chkEq("R10 port", v, 32'h0000_01F0);
    completeReq(32'h0000_5A5A, 0, "same-cycle");
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_writeAccess();
    t_readAccess();
    t_idleComplete();
    t_irq();
    t_unmapped();
    t_sameCycle();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule